// File: doc/BRIEF.md
# Receive Byte Queue with Interrupt Flags

This block sits on the receive side of a serial bus controller. It stores up to 32 bytes that the bus engine hands over one at a time. The processor drains them through a read strobe. Alongside the data path it keeps three receive status conditions:

- a level flag that is high while the buffer holds at least a programmed number of bytes;
- a sticky overflow flag for a byte that arrived with no room left;
- a sticky underflow flag for a read made while the buffer was empty.

A mask register selects which of these conditions reach a single registered interrupt line.

Software disables the block by clearing the enable input. The level flag drops at once. The buffer keeps running, and the sticky flags keep their values, until the bus engine reports idle. At that point an internal run signal falls. This flushes the buffer and clears both sticky flags. While run is low, bytes pushed and reads requested are ignored.

Status bit positions are fixed: bit 0 is underflow, bit 1 is overflow and bit 2 is the level flag. The mask register uses the same bit positions.

Top module: `rx_byte_queue`

## Requirements
- R1: The buffer holds 32 bytes and returns them in arrival order. A read strobe in one cycle places the oldest byte on `rdata_o` after the next clock edge.
- R2: Status bit 2 is high exactly when `enable_i` is 1 and the fill level is greater than or equal to `thresh_i`. It follows the fill level, so it falls as soon as the level drops below the threshold.
- R3: Clearing `enable_i` forces status bit 2 low in the same cycle, even while the bus engine is still busy.
- R4: A push while the buffer holds 32 bytes, with no read in the same cycle, sets status bit 1. The byte is discarded and the stored bytes are unchanged.
- R5: A push and a read in the same cycle on a full buffer act as a read followed by a write. Both take effect and status bit 1 is not set.
- R6: A read while the buffer is empty sets status bit 0 and returns 0 on `rdata_o`. The read position does not move, so the next byte pushed is the next byte read.
- R7: The internal run signal falls at the first clock edge where `enable_i` is 0 and `bus_idle_i` is 1, and rises at the first clock edge where `enable_i` is 1. Until run falls, bits 0 and 1 keep their value. One edge after run falls, both bits are 0. While run is low the buffer is empty and pushes and reads have no effect.
- R8: `masked_stat_o` equals `raw_stat_o` ANDed with the mask. The mask resets to 3'b111 and is loaded from `mask_wdata_i` at a clock edge where `mask_we_i` is 1.
- R9: `irq_o` is the OR of the three masked status bits, registered with one cycle of latency.
- R10: After reset, status bits 0 and 1, `irq_o` and `rdata_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Software enable bit |
| bus_idle_i | input | 1 | High while the bus state machines are idle |
| push_i | input | 1 | Byte-arrival strobe from the bus engine |
| push_data_i | input | 8 | Arriving byte |
| pop_i | input | 1 | Processor read strobe |
| thresh_i | input | 6 | Fill level at which bit 2 is set |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 3 | New mask value |
| rdata_o | output | 8 | Byte returned by the last read |
| raw_stat_o | output | 3 | Unmasked status {level, overflow, underflow} |
| masked_stat_o | output | 3 | Status ANDed with the mask |
| mask_o | output | 3 | Current mask register |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The level flag is tried over a table of fill-level and threshold pairs. The table covers a threshold of zero, levels one below, equal to and above the threshold, and a full buffer against a threshold of 32. These pairs separate an off-by-one comparison from a correct one.

Ordering is tried with a full 32-byte fill and drain of distinct values. The full-buffer cases contrast a push alone, which must drop the byte and raise overflow, with a push paired with a read, which must store the byte and leave overflow low. An empty read followed by a push shows whether the read position slipped.

The disable sequence holds idle low for several cycles and then raises it. This separates the immediate fall of the level flag from the delayed clearing of the sticky flags and the flush.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // Status bit positions: bit 2 level, bit 1 overflow, bit 0 underflow
    typedef struct packed {
        logic lvl;
        logic ovf;
        logic unf;
    } rxq_stat_t;

    localparam int STAT_W = 3;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          push_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          pop_i,
    output logic [DW-1:0] rdata_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_ev_o,
    output logic          unf_ev_o
);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rd;
    } store_t;

    store_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic do_push, do_pop, full;

    function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CW'(DEPTH));
        do_pop   = run_i && pop_i && (st_q.cnt != '0);
        unf_ev_o = run_i && pop_i && (st_q.cnt == '0);
        do_push  = run_i && push_i && (!full || do_pop);
        ovf_ev_o = run_i && push_i && full && !do_pop;
        if (!run_i) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wp = step_ptr(st_q.wp);
            end
            if (do_pop) begin
                st_d.rp = step_ptr(st_q.rp);
                st_d.rd = mem_q[st_q.rp];
            end else if (unf_ev_o) begin
                st_d.rd = '0;
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[st_q.wp] <= wdata_i;
        end
    end

    assign rdata_o = st_q.rd;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          enable_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] thresh_i,
    input  logic          ovf_ev_i,
    input  logic          unf_ev_i,
    output rxq_stat_t     stat_o
);

    typedef struct packed {
        logic ovf;
        logic unf;
    } sticky_t;

    sticky_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (!run_i) begin
            fl_d = '0;
        end else begin
            fl_d.ovf = fl_q.ovf | ovf_ev_i;
            fl_d.unf = fl_q.unf | unf_ev_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign stat_o.lvl = enable_i && (cnt_i >= thresh_i);
    assign stat_o.ovf = fl_q.ovf;
    assign stat_o.unf = fl_q.unf;

endmodule

// File: rtl/rxq_gate.sv
module rxq_gate
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              bus_idle_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    input  rxq_stat_t         raw_i,
    output logic              run_o,
    output logic [STAT_W-1:0] mask_o,
    output logic [STAT_W-1:0] masked_o,
    output logic              irq_o
);

    typedef struct packed {
        logic              run;
        logic [STAT_W-1:0] mask;
        logic              irq;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d     = g_q;
        g_d.run = enable_i | (g_q.run & ~bus_idle_i);
        if (mask_we_i) begin
            g_d.mask = mask_wdata_i;
        end
        g_d.irq = |(raw_i & g_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{run: 1'b0, mask: '1, irq: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign run_o    = g_q.run;
    assign mask_o   = g_q.mask;
    assign masked_o = raw_i & g_q.mask;
    assign irq_o    = g_q.irq;

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              bus_idle_i,
    input  logic              push_i,
    input  logic [DW-1:0]     push_data_i,
    input  logic              pop_i,
    input  logic [CW-1:0]     thresh_i,
    input  logic              mask_we_i,
    input  logic [STAT_W-1:0] mask_wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic [STAT_W-1:0] raw_stat_o,
    output logic [STAT_W-1:0] masked_stat_o,
    output logic [STAT_W-1:0] mask_o,
    output logic              irq_o
);

    logic          run_w;
    logic [CW-1:0] cnt_w;
    logic          ovf_ev_w, unf_ev_w;
    rxq_stat_t     stat_w;

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .push_i   (push_i),
        .wdata_i  (push_data_i),
        .pop_i    (pop_i),
        .rdata_o  (rdata_o),
        .cnt_o    (cnt_w),
        .ovf_ev_o (ovf_ev_w),
        .unf_ev_o (unf_ev_w)
    );

    rxq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_w),
        .enable_i (enable_i),
        .cnt_i    (cnt_w),
        .thresh_i (thresh_i),
        .ovf_ev_i (ovf_ev_w),
        .unf_ev_i (unf_ev_w),
        .stat_o   (stat_w)
    );

    rxq_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .bus_idle_i   (bus_idle_i),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .raw_i        (stat_w),
        .run_o        (run_w),
        .mask_o       (mask_o),
        .masked_o     (masked_stat_o),
        .irq_o        (irq_o)
    );

    assign raw_stat_o = stat_w;

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable_i,
    input logic          pop_i,
    input logic [DW-1:0] rdata_o,
    input logic [2:0]    raw_stat_o,
    input logic [2:0]    masked_stat_o,
    input logic          irq_o,
    input logic          run,
    input logic [CW-1:0] cnt
);

    // R1
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R3
    lvl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !raw_stat_o[2]);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pop_i && cnt == '0) |=> (raw_stat_o[0] && rdata_o == '0));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && raw_stat_o[1]) |=> raw_stat_o[1]);

    // R7
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0 && raw_stat_o[1:0] == 2'b00));

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == |$past(masked_stat_o)));

endmodule

bind rx_byte_queue rxq_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable_i      (enable_i),
    .pop_i         (pop_i),
    .rdata_o       (rdata_o),
    .raw_stat_o    (raw_stat_o),
    .masked_stat_o (masked_stat_o),
    .irq_o         (irq_o),
    .run           (run_w),
    .cnt           (cnt_w)
);

// File: tb/sim_rx_byte_queue.sv
`timescale 1ns/1ps
module sim_rx_byte_queue;

    logic       clk = 1'b0;
    logic       rst_n, enable_i, bus_idle_i, push_i, pop_i, mask_we_i;
    logic [7:0] push_data_i;
    logic [5:0] thresh_i;
    logic [2:0] mask_wdata_i;
    logic [7:0] rdata_o;
    logic [2:0] raw_stat_o, masked_stat_o, mask_o;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rx_byte_queue u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .bus_idle_i(bus_idle_i),
        .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
        .thresh_i(thresh_i), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
        .rdata_o(rdata_o), .raw_stat_o(raw_stat_o), .masked_stat_o(masked_stat_o),
        .mask_o(mask_o), .irq_o(irq_o)
    );

    // {fill count, threshold}
    localparam logic [11:0] VEC [8] = '{
        {6'd0,  6'd0},  {6'd1,  6'd2},  {6'd2,  6'd2},  {6'd3,  6'd2},
        {6'd31, 6'd32}, {6'd32, 6'd32}, {6'd16, 6'd20}, {6'd5,  6'd1}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic push_b(input logic [7:0] d);
        push_i = 1'b1;
        push_data_i = d;
        cyc();
        push_i = 1'b0;
    endtask

    task automatic pop_b(output logic [7:0] d);
        pop_i = 1'b1;
        cyc();
        pop_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic flush();
        enable_i = 1'b0;
        bus_idle_i = 1'b1;
        cyc();
        cyc();
        enable_i = 1'b1;
        cyc();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rst_n = 1'b0; enable_i = 1'b0; bus_idle_i = 1'b1; push_i = 1'b0; pop_i = 1'b0;
        mask_we_i = 1'b0; mask_wdata_i = '0; push_data_i = '0; thresh_i = 6'd32;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R10 / R8 reset state
        chk(raw_stat_o == 3'b000, "R10 raw", raw_stat_o, 0);
        chk(irq_o == 1'b0, "R10 irq", irq_o, 0);
        chk(rdata_o == 8'h00, "R10 rdata", rdata_o, 0);
        chk(mask_o == 3'b111, "R8 mask reset", mask_o, 7);

        // R2 level flag table
        for (int i = 0; i < 8; i++) begin
            int n, t;
            n = int'(VEC[i][11:6]);
            t = int'(VEC[i][5:0]);
            flush();
            thresh_i = VEC[i][5:0];
            for (int k = 0; k < n; k++) push_b(8'(k));
            #1;
            chk(raw_stat_o[2] == (n >= t), "R2 level", raw_stat_o[2], int'(n >= t));
        end
        // R2 falls when drained below threshold
        flush();
        thresh_i = 6'd2;
        push_b(8'h11); push_b(8'h22);
        chk(raw_stat_o[2] == 1'b1, "R2 at level", raw_stat_o[2], 1);
        pop_b(d);
        chk(raw_stat_o[2] == 1'b0, "R2 below level", raw_stat_o[2], 0);

        // R1 order over a full buffer
        flush();
        for (int k = 0; k < 32; k++) push_b(8'(k * 7 + 3));
        for (int k = 0; k < 32; k++) begin
            pop_b(d);
            chk(d == 8'(k * 7 + 3), "R1 order", d, k * 7 + 3);
        end

        // R4 overflow, contents unchanged; R6 underflow
        flush();
        for (int k = 0; k < 32; k++) push_b(8'(k + 64));
        push_b(8'hAA);
        chk(raw_stat_o[1] == 1'b1, "R4 ovf set", raw_stat_o[1], 1);
        for (int k = 0; k < 32; k++) begin
            pop_b(d);
            chk(d == 8'(k + 64), "R4 contents", d, k + 64);
        end
        pop_b(d);
        chk(d == 8'h00, "R6 empty data", d, 0);
        chk(raw_stat_o[0] == 1'b1, "R6 unf set", raw_stat_o[0], 1);
        push_b(8'h55);
        pop_b(d);
        chk(d == 8'h55, "R6 pointer kept", d, 8'h55);

        // R5 push with read on full
        flush();
        for (int k = 0; k < 32; k++) push_b(8'(k + 1));
        push_i = 1'b1; pop_i = 1'b1; push_data_i = 8'hEE;
        cyc();
        push_i = 1'b0; pop_i = 1'b0;
        chk(rdata_o == 8'd1, "R5 read value", rdata_o, 1);
        chk(raw_stat_o[1] == 1'b0, "R5 no ovf", raw_stat_o[1], 0);
        for (int k = 1; k < 32; k++) begin
            pop_b(d);
            chk(d == 8'(k + 1), "R5 drain", d, k + 1);
        end
        pop_b(d);
        chk(d == 8'hEE, "R5 stored", d, 8'hEE);

        // R3 immediate level drop, R7 sticky then clear and flush
        flush();
        thresh_i = 6'd4;
        for (int k = 0; k < 33; k++) push_b(8'(k));
        chk(raw_stat_o[2] == 1'b1, "R2 full level", raw_stat_o[2], 1);
        enable_i = 1'b0; bus_idle_i = 1'b0;
        #1;
        chk(raw_stat_o[2] == 1'b0, "R3 immediate", raw_stat_o[2], 0);
        repeat (3) cyc();
        chk(raw_stat_o[1] == 1'b1, "R7 held busy", raw_stat_o[1], 1);
        bus_idle_i = 1'b1;
        cyc();
        cyc();
        chk(raw_stat_o[1:0] == 2'b00, "R7 cleared", raw_stat_o[1:0], 0);
        push_b(8'h77); push_b(8'h78);
        enable_i = 1'b1;
        cyc();
        thresh_i = 6'd1;
        #1;
        chk(raw_stat_o[2] == 1'b0, "R7 flushed", raw_stat_o[2], 0);
        pop_b(d);
        chk(d == 8'h00 && raw_stat_o[0], "R7 ignored push", d, 0);

        // R8 / R9 masking and interrupt latency
        flush();
        thresh_i = 6'd32;
        mask_we_i = 1'b1; mask_wdata_i = 3'b000;
        cyc();
        mask_we_i = 1'b0;
        pop_b(d);
        chk(masked_stat_o == 3'b000, "R8 masked off", masked_stat_o, 0);
        cyc();
        chk(irq_o == 1'b0, "R9 irq off", irq_o, 0);
        mask_we_i = 1'b1; mask_wdata_i = 3'b001;
        cyc();
        mask_we_i = 1'b0;
        chk(masked_stat_o == 3'b001, "R8 masked on", masked_stat_o, 1);
        chk(irq_o == 1'b0, "R9 latency", irq_o, 0);
        cyc();
        chk(irq_o == 1'b1, "R9 irq on", irq_o, 1);

        finish_run();
    end

endmodule